// File: doc/BRIEF.md
# Speculative Load Tracking Table

This block records loads that were issued early, ahead of stores that might write the same bytes. When such a load issues, the pipeline allocates an entry. The entry is tagged with the load's destination register number and holds the byte address and access size. Every store then compares its byte range with all live entries. Any entry whose range it touches is killed.

Later, a check operation names a destination register and asks whether its entry is still live. There are two kinds of check. A load-type check raises a reissue request when the entry is gone. A branch-type check raises a redirect request, so that the front end jumps to recovery code. A check can also be marked as clearing, which consumes the entry.

Checks are combinational lookups of the table as it stood at the start of the cycle. Stores, allocations and clearing checks update the table at the clock edge. When several updates fall in one cycle, they apply in this order: store kills, then check clears, then the allocation write.

Top module: `spec_load_tracker`

## Requirements
- R1: After reset no entry is live, so every check reports a miss.
- R2: An allocation makes an entry for its register that a check in any later cycle reports as a hit.
- R3: Allocating to a register that already owns a live entry rewrites that entry in place, with the new address and size. A store to the old range no longer kills it.
- R4: A store kills an entry when the two byte ranges share at least one byte. A range starts at its address and spans size bytes, with sizes from 1 to 8.
- R5: A store whose range only abuts an entry's range, directly below or directly above, leaves the entry live.
- R6: A single store kills every live entry it overlaps in the same cycle.
- R7: An allocation and an overlapping store in the same cycle leave the newly written entry live.
- R8: A load-type check (`chk_is_branch`=0) drives `chk_reload` high exactly when its register has no live entry.
- R9: A branch-type check (`chk_is_branch`=1) drives `chk_redirect` high exactly when its register has no live entry. `chk_reload` stays low.
- R10: A check with `chk_clear`=1 removes the entry it finds. A check with `chk_clear`=0 leaves the table unchanged.
- R11: A new register takes the slot at a round-robin pointer that starts at slot 0 after reset. The pointer advances only on allocations that do not reuse an entry. Allocating 17 distinct registers therefore evicts the first one.
- R12: A check reports the table contents before the updates of its own cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_vld | input | 1 | Early load allocates an entry |
| alloc_reg | input | REG_W | Destination register of the early load |
| alloc_addr | input | ADDR_W | Byte address of the early load |
| alloc_size | input | SIZE_W | Access size in bytes (1..8) |
| st_vld | input | 1 | Store present |
| st_addr | input | ADDR_W | Store byte address |
| st_size | input | SIZE_W | Store size in bytes (1..8) |
| chk_vld | input | 1 | Check present |
| chk_reg | input | REG_W | Register being checked |
| chk_is_branch | input | 1 | 1: branch-type check, 0: load-type check |
| chk_clear | input | 1 | Consume the entry found |
| chk_hit | output | 1 | Checked register has a live entry |
| chk_reload | output | 1 | Load-type check missed; reissue the load |
| chk_redirect | output | 1 | Branch-type check missed; go to recovery code |

## Verification
The interesting collision is an allocation and a store landing in the same cycle. The store may overlap the new entry's own range, or it may overlap an older entry that the allocation rewrites. The bench drives both inputs between the same pair of clock edges. A check in the following cycle must still report a hit for the new entry. A second collision is a check that falls in the same cycle as an update to its own register. The bench judges that the check reports the old state and that a later check reports the new one.

// File: rtl/spec_trk_pkg.sv
package spec_trk_pkg;
  localparam int unsigned DEF_ADDR_W  = 32;
  localparam int unsigned DEF_REG_W   = 7;
  localparam int unsigned DEF_SIZE_W  = 4;
  localparam int unsigned DEF_ENTRIES = 16;

  typedef enum logic {CHK_LOAD = 1'b0, CHK_BRANCH = 1'b1} chk_kind_e;
endpackage

// File: rtl/spec_trk_overlap.sv
module spec_trk_overlap #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SIZE_W = 4
) (
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [SIZE_W-1:0] a_size,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [SIZE_W-1:0] b_size,
  output logic              overlap
);
  // one spare bit so ranges ending at the top of memory do not wrap
  logic [ADDR_W:0] a_end, b_end;

  always_comb begin
    a_end   = {1'b0, a_addr} + {{(ADDR_W+1-SIZE_W){1'b0}}, a_size};
    b_end   = {1'b0, b_addr} + {{(ADDR_W+1-SIZE_W){1'b0}}, b_size};
    overlap = (a_size != '0) && (b_size != '0) &&
              ({1'b0, a_addr} < b_end) && ({1'b0, b_addr} < a_end);
  end
endmodule

// File: rtl/spec_trk_victim.sv
module spec_trk_victim #(
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_vld,
  input  logic [ENTRIES-1:0] reuse_vec,
  output logic [IDX_W-1:0]   wr_idx
);
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [IDX_W-1:0] reuse_idx;
  logic             reuse_any;

  always_comb begin
    reuse_idx = '0;
    reuse_any = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (reuse_vec[i]) begin
        reuse_idx = IDX_W'(i);
        reuse_any = 1'b1;
      end
    end
    wr_idx = reuse_any ? reuse_idx : ptr_q;
    ptr_d  = ptr_q;
    if (alloc_vld && !reuse_any) begin
      ptr_d = (ptr_q == IDX_W'(ENTRIES-1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else begin
      ptr_q <= ptr_d;
    end
  end

  assert_ptr_hold_on_reuse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc_vld || reuse_any) |=> ptr_q == $past(ptr_q));
  assert_reuse_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reuse_vec));
endmodule

// File: rtl/spec_load_tracker.sv
module spec_load_tracker
  import spec_trk_pkg::*;
#(
  parameter int unsigned ADDR_W  = DEF_ADDR_W,
  parameter int unsigned REG_W   = DEF_REG_W,
  parameter int unsigned SIZE_W  = DEF_SIZE_W,
  parameter int unsigned ENTRIES = DEF_ENTRIES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_vld,
  input  logic [REG_W-1:0]  alloc_reg,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic [SIZE_W-1:0] alloc_size,
  input  logic              st_vld,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [SIZE_W-1:0] st_size,
  input  logic              chk_vld,
  input  logic [REG_W-1:0]  chk_reg,
  input  logic              chk_is_branch,
  input  logic              chk_clear,
  output logic              chk_hit,
  output logic              chk_reload,
  output logic              chk_redirect
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] valid_q, valid_d;
  logic [REG_W-1:0]   tag_q  [ENTRIES];
  logic [ADDR_W-1:0]  addr_q [ENTRIES];
  logic [SIZE_W-1:0]  size_q [ENTRIES];

  logic [ENTRIES-1:0] ovl, st_kill, reuse_vec, chk_match;
  logic [IDX_W-1:0]   wr_idx;
  chk_kind_e          kind;

  spec_trk_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_vld (alloc_vld),
    .reuse_vec (reuse_vec),
    .wr_idx    (wr_idx)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    spec_trk_overlap #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_ovl (
      .a_addr  (st_addr),
      .a_size  (st_size),
      .b_addr  (addr_q[g]),
      .b_size  (size_q[g]),
      .overlap (ovl[g])
    );

    assign st_kill[g]   = st_vld && valid_q[g] && ovl[g];
    assign reuse_vec[g] = valid_q[g] && (tag_q[g] == alloc_reg);
    assign chk_match[g] = chk_vld && valid_q[g] && (tag_q[g] == chk_reg);

    // payload registers: clock enable on allocation, no reset needed
    always_ff @(posedge clk) begin
      if (alloc_vld && (wr_idx == IDX_W'(g))) begin
        tag_q[g]  <= alloc_reg;
        addr_q[g] <= alloc_addr;
        size_q[g] <= alloc_size;
      end
    end

    assert_store_kills_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_kill[g] && !(alloc_vld && wr_idx == IDX_W'(g))) |=> !valid_q[g]);
  end

  // order of updates: store kills, clearing check, then allocation write
  always_comb begin
    valid_d = valid_q & ~st_kill;
    if (chk_clear) begin
      valid_d = valid_d & ~chk_match;
    end
    if (alloc_vld) begin
      valid_d[wr_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_comb begin
    kind         = chk_kind_e'(chk_is_branch);
    chk_hit      = |chk_match;
    chk_reload   = chk_vld && (kind == CHK_LOAD)   && !chk_hit;
    chk_redirect = chk_vld && (kind == CHK_BRANCH) && !chk_hit;
  end

  assert_alloc_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_vld |=> valid_q[$past(wr_idx)] && (tag_q[$past(wr_idx)] == $past(alloc_reg)));
  assert_new_entry_survives_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_vld && st_vld) |=> valid_q[$past(wr_idx)]);
  assert_single_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
    chk_vld |-> $countones(chk_match) <= 1);
  assert_outcomes_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(chk_reload && chk_redirect));
  assert_miss_needs_check_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_vld |-> !chk_reload && !chk_redirect && !chk_hit);
  assert_plain_check_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!chk_clear && !st_vld && !alloc_vld) |=> $stable(valid_q));
endmodule

// File: tb/test_spec_load_tracker.sv
module test_spec_load_tracker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        alloc_vld;
  logic [6:0]  alloc_reg;
  logic [31:0] alloc_addr;
  logic [3:0]  alloc_size;
  logic        st_vld;
  logic [31:0] st_addr;
  logic [3:0]  st_size;
  logic        chk_vld;
  logic [6:0]  chk_reg;
  logic        chk_is_branch;
  logic        chk_clear;
  logic        chk_hit, chk_reload, chk_redirect;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  spec_load_tracker i_spec_load_tracker (
    .clk(clk), .rst_n(rst_n),
    .alloc_vld(alloc_vld), .alloc_reg(alloc_reg), .alloc_addr(alloc_addr), .alloc_size(alloc_size),
    .st_vld(st_vld), .st_addr(st_addr), .st_size(st_size),
    .chk_vld(chk_vld), .chk_reg(chk_reg), .chk_is_branch(chk_is_branch), .chk_clear(chk_clear),
    .chk_hit(chk_hit), .chk_reload(chk_reload), .chk_redirect(chk_redirect)
  );

  task automatic expect_eq(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    alloc_vld = 0; alloc_reg = '0; alloc_addr = '0; alloc_size = '0;
    st_vld = 0; st_addr = '0; st_size = '0;
    chk_vld = 0; chk_reg = '0; chk_is_branch = 0; chk_clear = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst_n = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic alloc(input logic [6:0] r, input logic [31:0] a, input logic [3:0] s);
    @(negedge clk);
    alloc_vld = 1; alloc_reg = r; alloc_addr = a; alloc_size = s;
    @(negedge clk);
    alloc_vld = 0;
  endtask

  task automatic store(input logic [31:0] a, input logic [3:0] s);
    @(negedge clk);
    st_vld = 1; st_addr = a; st_size = s;
    @(negedge clk);
    st_vld = 0;
  endtask

  // one check cycle; results sampled mid-cycle
  task automatic probe(input string req, input logic [6:0] r, input logic br, input logic clr,
                       input logic exp_hit);
    @(negedge clk);
    chk_vld = 1; chk_reg = r; chk_is_branch = br; chk_clear = clr;
    #1;
    expect_eq(req, "hit", chk_hit, exp_hit);
    expect_eq(req, "reload", chk_reload, !br && !exp_hit);
    expect_eq(req, "redirect", chk_redirect, br && !exp_hit);
    @(negedge clk);
    chk_vld = 0; chk_clear = 0;
  endtask

  task automatic t_reset();
    do_reset();
    probe("R1", 7'd5, 0, 0, 0);
    probe("R1", 7'd0, 1, 0, 0);
  endtask

  task automatic t_alloc_hit();
    do_reset();
    alloc(7'd10, 32'h100, 4'd8);
    probe("R2", 7'd10, 0, 0, 1);
    probe("R8", 7'd11, 0, 0, 0);
    probe("R9", 7'd10, 1, 0, 1);
  endtask

  task automatic t_overlap();
    do_reset();
    alloc(7'd11, 32'h200, 4'd8);
    store(32'h207, 4'd1);
    probe("R4", 7'd11, 0, 0, 0);
    probe("R9", 7'd11, 1, 0, 0);
    alloc(7'd12, 32'h300, 4'd8);
    store(32'h2FC, 4'd4);
    probe("R5", 7'd12, 0, 0, 1);
    store(32'h308, 4'd8);
    probe("R5", 7'd12, 0, 0, 1);
    store(32'h2FD, 4'd4);
    probe("R4", 7'd12, 0, 0, 0);
  endtask

  task automatic t_multi();
    do_reset();
    alloc(7'd1, 32'h400, 4'd8);
    alloc(7'd2, 32'h404, 4'd4);
    alloc(7'd3, 32'h500, 4'd8);
    store(32'h402, 4'd4);
    probe("R6", 7'd1, 0, 0, 0);
    probe("R6", 7'd2, 0, 0, 0);
    probe("R6", 7'd3, 0, 0, 1);
  endtask

  task automatic t_same_cycle();
    do_reset();
    alloc(7'd20, 32'h600, 4'd8);
    @(negedge clk);
    alloc_vld = 1; alloc_reg = 7'd21; alloc_addr = 32'h700; alloc_size = 4'd8;
    st_vld = 1; st_addr = 32'h700; st_size = 4'd8;
    @(negedge clk);
    alloc_vld = 0; st_vld = 0;
    probe("R7", 7'd21, 0, 0, 1);
    @(negedge clk);
    alloc_vld = 1; alloc_reg = 7'd20; alloc_addr = 32'h600; alloc_size = 4'd8;
    st_vld = 1; st_addr = 32'h604; st_size = 4'd2;
    @(negedge clk);
    alloc_vld = 0; st_vld = 0;
    probe("R7", 7'd20, 0, 0, 1);
  endtask

  task automatic t_overwrite();
    do_reset();
    alloc(7'd30, 32'h800, 4'd8);
    alloc(7'd30, 32'h900, 4'd8);
    store(32'h800, 4'd8);
    probe("R3", 7'd30, 0, 0, 1);
    store(32'h900, 4'd8);
    probe("R3", 7'd30, 0, 0, 0);
  endtask

  task automatic t_clear();
    do_reset();
    alloc(7'd40, 32'hA00, 4'd8);
    probe("R10", 7'd40, 0, 0, 1);
    probe("R10", 7'd40, 1, 0, 1);
    probe("R10", 7'd40, 0, 1, 1);
    probe("R10", 7'd40, 0, 0, 0);
  endtask

  task automatic t_round_robin();
    do_reset();
    for (int i = 1; i <= 16; i++) alloc(7'(i), 32'h1000 + 32'(i) * 16, 4'd8);
    for (int i = 1; i <= 16; i++) probe("R11", 7'(i), 0, 0, 1);
    alloc(7'd17, 32'h2000, 4'd8);
    probe("R11", 7'd1, 0, 0, 0);
    probe("R11", 7'd2, 0, 0, 1);
    probe("R11", 7'd17, 0, 0, 1);
    alloc(7'd5, 32'h3000, 4'd8);
    alloc(7'd18, 32'h3100, 4'd8);
    probe("R11", 7'd2, 0, 0, 0);
    probe("R11", 7'd3, 0, 0, 1);
    probe("R11", 7'd5, 0, 0, 1);
  endtask

  task automatic t_view();
    do_reset();
    @(negedge clk);
    alloc_vld = 1; alloc_reg = 7'd50; alloc_addr = 32'hB00; alloc_size = 4'd8;
    chk_vld = 1; chk_reg = 7'd50; chk_is_branch = 0; chk_clear = 0;
    #1;
    expect_eq("R12", "hit before alloc", chk_hit, 0);
    @(negedge clk);
    alloc_vld = 0; chk_vld = 0;
    probe("R12", 7'd50, 0, 0, 1);
    @(negedge clk);
    st_vld = 1; st_addr = 32'hB00; st_size = 4'd1;
    chk_vld = 1; chk_reg = 7'd50; chk_is_branch = 1;
    #1;
    expect_eq("R12", "hit before store", chk_hit, 1);
    expect_eq("R12", "redirect before store", chk_redirect, 0);
    @(negedge clk);
    st_vld = 0; chk_vld = 0;
    probe("R12", 7'd50, 1, 0, 0);
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    t_reset();
    t_alloc_hit();
    t_overlap();
    t_multi();
    t_same_cycle();
    t_overwrite();
    t_clear();
    t_round_robin();
    t_view();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule